// File: doc/BRIEF.md
# NAND Flash Host Bus Bridge

This block connects a 16-bit register-mapped host bus to an 8-bit raw NAND flash device. Software selects the NAND bus phase by writing an encoded byte to a mode register. The bits of that byte drive chip enable, the command latch and the address latch directly. A data port then turns each host access into NAND byte cycles. A 16-bit access becomes two byte cycles, low lane first. An 8-bit access becomes one byte cycle, which is how commands and addresses are sent.

Each NAND byte cycle has a fixed setup time, a strobe-low time set by a parameter, and a fixed hold time. The host request stays pending until every byte cycle of the access has finished. The block then answers with a single-cycle done pulse. The device's ready/busy line is synchronized into the clock domain. Its level appears as a busy flag in a status register. Its rising edge latches a ready request, which drives the interrupt output when the mask allows it.

Top module: `nand_host_bridge`

## Requirements
- R1: After reset the mode register reads 0x00, chip enable is inactive (nand_ce_n=1), CLE and ALE are 0, both strobes are high, and irq and host_done are 0.
- R2: The mode register sits at byte offset 4. Bit 4 activates chip enable (nand_ce_n is its inverse). While bit 4 is set, bit 0 drives CLE and bit 1 drives ALE. Thus 0x94 selects the data phase, 0x95 the command phase, 0x96 the address phase, and 0x00 standby.
- R3: The mode register reads back all 8 bits as written. Bits 2, 3, 5 and 6 have no effect on any pin or transfer.
- R4: A 16-bit write to offset 0 (host_wide=1) performs two NAND write cycles. Bits 7:0 go out first, then bits 15:8. The device latches each byte on the rising edge of nand_we_n.
- R5: An 8-bit write to offset 0 (host_wide=0) performs exactly one NAND write cycle carrying host_wdata[7:0].
- R6: A 16-bit read of offset 0 performs two NAND read cycles. The first byte fetched lands in bits 7:0 and the second in bits 15:8. An 8-bit read performs one cycle, returns the byte in bits 7:0 and returns 0 in bits 15:8.
- R7: Each byte cycle holds exactly one strobe (nand_we_n or nand_re_n) low for STROBE_CLKS clocks. Write data stays driven and stable for the whole cycle. The two strobes are never low together.
- R8: When mode bit 4 or mode bit 7 is clear, a data-port access makes no NAND cycle. A write in that state is dropped, and a read returns 0.
- R9: The status register sits at offset 5. Its bit 7 reads 1 while the synchronized nand_rb is low (busy). Its other bits read 0.
- R10: A rising edge of the synchronized nand_rb sets bit 0 of the interrupt status register at offset 6. A falling edge does not set it.
- R11: A write to offset 6 clears the pending bits whose data bits are 1, so 0x0F clears everything and 0x00 clears nothing. A rising edge in the same cycle as a clear wins.
- R12: The mask register sits at offset 7 and reads back as written. irq is 1 exactly when the pending bit, mask bit 0 and mask bit 7 are all 1. Writing 0x81 enables the interrupt and 0x00 disables it.
- R13: host_done is a one-cycle pulse. A register access completes one cycle after it is accepted. A data-port access completes after all of its byte cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until host_done |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Byte offset of the register |
| host_wide | input | 1 | Data port: 1 = 16-bit access, 0 = 8-bit access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_done |
| host_done | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_dq_o | output | 8 | NAND data out |
| nand_dq_oe | output | 1 | NAND data output enable |
| nand_dq_i | input | 8 | NAND data in |
| nand_rb | input | 1 | NAND ready (1) / busy (0) |
| irq | output | 1 | Ready interrupt request |

## Verification
Each result falls due a fixed number of cycles after its stimulus.
- **Register access:** host_done appears one cycle after the request is accepted. Mode pin changes and irq follow a mask write in that same cycle.
- **Data-port access:** a byte cycle lasts SETUP_CLKS+STROBE_CLKS+HOLD_CLKS clocks. An access finishes one or two byte cycles after acceptance.
- **Ready/busy input:** a change reaches the status bit SYNC_STAGES cycles later and the pending bit one cycle after that.

The bench counts the falling clock edges from request to done and compares that count with these sums. It waits several cycles beyond the synchronizer depth before it reads status or pending state. Its NAND model records each byte at the strobe's rising edge and measures every strobe-low run at falling clock edges.

// File: rtl/nhb_pkg.sv
package nhb_pkg;
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_MODE = 3'd4;
  localparam logic [2:0] OFF_STAT = 3'd5;
  localparam logic [2:0] OFF_PEND = 3'd6;
  localparam logic [2:0] OFF_MASK = 3'd7;

  localparam int MB_CLE = 0;
  localparam int MB_ALE = 1;
  localparam int MB_CE  = 4;
  localparam int MB_WE  = 7;

  typedef enum logic [1:0] {EN_IDLE, EN_SETUP, EN_STROBE, EN_HOLD} eng_st_t;
  typedef enum logic [1:0] {BR_IDLE, BR_XFER, BR_DONE} br_st_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic port_open(input logic [7:0] m);
    return m[MB_CE] & m[MB_WE];
  endfunction

  function automatic logic irq_of(input logic pend, input logic [7:0] msk);
    return pend & msk[0] & msk[7];
  endfunction
endpackage

// File: rtl/nhb_byte_engine.sv
module nhb_byte_engine
  import nhb_pkg::*;
#(
  parameter int NW          = 8,
  parameter int SETUP_CLKS  = 1,
  parameter int STROBE_CLKS = 3,
  parameter int HOLD_CLKS   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd,
  input  logic [NW-1:0] wbyte,
  output logic          we_n,
  output logic          re_n,
  output logic [NW-1:0] dq_o,
  output logic          dq_oe,
  input  logic [NW-1:0] dq_i,
  output logic [NW-1:0] rbyte,
  output logic          fin
);
  localparam int MAXC = max3(SETUP_CLKS, STROBE_CLKS, HOLD_CLKS);
  localparam int CW   = $clog2(MAXC) + 1;

  eng_st_t       st;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic [NW-1:0] byte_q;
  logic          strobe_low;

  assign fin   = (st == EN_HOLD) && (cnt == '0);
  assign we_n  = !((st == EN_STROBE) && !rd_q);
  assign re_n  = !((st == EN_STROBE) && rd_q);
  assign dq_oe = (st != EN_IDLE) && !rd_q;
  assign dq_o  = byte_q;
  assign strobe_low = !we_n || !re_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= EN_IDLE;
      cnt    <= '0;
      rd_q   <= 1'b0;
      byte_q <= '0;
      rbyte  <= '0;
    end else if (start && (st == EN_IDLE || fin)) begin
      st     <= EN_SETUP;
      cnt    <= CW'(SETUP_CLKS - 1);
      rd_q   <= rd;
      byte_q <= wbyte;
    end else begin
      case (st)
        EN_SETUP:
          if (cnt == '0) begin
            st  <= EN_STROBE;
            cnt <= CW'(STROBE_CLKS - 1);
          end else cnt <= cnt - 1'b1;
        EN_STROBE:
          if (cnt == '0) begin
            st  <= EN_HOLD;
            cnt <= CW'(HOLD_CLKS - 1);
            if (rd_q) rbyte <= dq_i;
          end else cnt <= cnt - 1'b1;
        EN_HOLD:
          if (cnt == '0) st <= EN_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= EN_IDLE;
      endcase
    end
  end

  // checker state: length of the current strobe-low run
  logic [CW-1:0] strobe_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_len <= '0;
    else if (strobe_low) strobe_len <= strobe_len + 1'b1;
    else strobe_len <= '0;
  end

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r7_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> (strobe_len < CW'(STROBE_CLKS)));
  a_r7_width_exact: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe_low) && !strobe_low) |-> ($past(strobe_len) == CW'(STROBE_CLKS - 1)));
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(dq_o));
endmodule

// File: rtl/nhb_ready_irq.sv
module nhb_ready_irq
  import nhb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rb,
  input  logic       clr_wr,
  input  logic       clr_bit,
  input  logic       mask_wr,
  input  logic [7:0] mask_data,
  output logic       busy,
  output logic [7:0] pend,
  output logic [7:0] mask,
  output logic       irq
);
  logic [SYNC_STAGES-1:0] sh;
  logic rb_s, rb_d, rb_rise, pend_q;

  assign rb_s    = sh[SYNC_STAGES-1];
  assign rb_rise = rb_s & ~rb_d;
  assign busy    = ~rb_s;
  assign pend    = {7'b0, pend_q};
  assign irq     = irq_of(pend_q, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '1;
      rb_d   <= 1'b1;
      pend_q <= 1'b0;
      mask   <= '0;
    end else begin
      sh     <= {sh[SYNC_STAGES-2:0], rb};
      rb_d   <= rb_s;
      pend_q <= (pend_q & ~(clr_wr & clr_bit)) | rb_rise;
      if (mask_wr) mask <= mask_data;
    end
  end

  a_r10_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rb_rise |=> pend[0]);
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bit && !rb_rise) |=> !pend[0]);
  a_r12_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend[0] && mask[7]));
endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
  import nhb_pkg::*;
#(
  parameter int HW          = 16,
  parameter int NW          = 8,
  parameter int SETUP_CLKS  = 1,
  parameter int STROBE_CLKS = 3,
  parameter int HOLD_CLKS   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [2:0]    host_addr,
  input  logic          host_wide,
  input  logic [HW-1:0] host_wdata,
  output logic [HW-1:0] host_rdata,
  output logic          host_done,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [NW-1:0] nand_dq_o,
  output logic          nand_dq_oe,
  input  logic [NW-1:0] nand_dq_i,
  input  logic          nand_rb,
  output logic          irq
);
  localparam int LANES = HW / NW;
  localparam int LIDX  = (LANES > 1) ? $clog2(LANES) : 1;

  br_st_t        st;
  logic [7:0]    mode_q;
  logic          wr_q, wide_q;
  logic [HW-1:0] wdata_q, rdata_q;
  logic [LIDX-1:0] lane_q, lane_next;

  logic accept, go, more;
  logic eng_start, eng_rd, eng_fin;
  logic [NW-1:0] eng_wbyte, eng_rbyte;
  logic st_busy, irq_clr, irq_mwr;
  logic [7:0] pend_b, mask_b;

  assign accept    = host_req && (st == BR_IDLE);
  assign go        = accept && (host_addr == OFF_DATA) && port_open(mode_q);
  assign lane_next = lane_q + 1'b1;
  assign more      = wide_q && (lane_q != LIDX'(LANES - 1));
  assign eng_start = go || ((st == BR_XFER) && eng_fin && more);
  assign eng_rd    = (st == BR_IDLE) ? !host_wr : !wr_q;
  assign eng_wbyte = (st == BR_IDLE) ? host_wdata[NW-1:0] : wdata_q[lane_next*NW +: NW];
  assign irq_clr   = accept && host_wr && (host_addr == OFF_PEND);
  assign irq_mwr   = accept && host_wr && (host_addr == OFF_MASK);

  assign host_done  = (st == BR_DONE);
  assign host_rdata = rdata_q;
  assign nand_ce_n  = ~mode_q[MB_CE];
  assign nand_cle   = mode_q[MB_CE] & mode_q[MB_CLE];
  assign nand_ale   = mode_q[MB_CE] & mode_q[MB_ALE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= BR_IDLE;
      mode_q  <= 8'h00;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      lane_q  <= '0;
    end else begin
      case (st)
        BR_IDLE:
          if (accept) begin
            rdata_q <= '0;
            wr_q    <= host_wr;
            wide_q  <= host_wide;
            wdata_q <= host_wdata;
            lane_q  <= '0;
            st      <= go ? BR_XFER : BR_DONE;
            if (host_wr && host_addr == OFF_MODE) mode_q <= host_wdata[7:0];
            if (!host_wr) begin
              case (host_addr)
                OFF_MODE: rdata_q <= HW'(mode_q);
                OFF_STAT: rdata_q <= HW'({st_busy, 7'b0});
                OFF_PEND: rdata_q <= HW'(pend_b);
                OFF_MASK: rdata_q <= HW'(mask_b);
                default:  rdata_q <= '0;
              endcase
            end
          end
        BR_XFER:
          if (eng_fin) begin
            if (!wr_q) rdata_q[lane_q*NW +: NW] <= eng_rbyte;
            if (more) lane_q <= lane_next;
            else st <= BR_DONE;
          end
        BR_DONE: st <= BR_IDLE;
        default: st <= BR_IDLE;
      endcase
    end
  end

  nhb_byte_engine #(
    .NW(NW), .SETUP_CLKS(SETUP_CLKS), .STROBE_CLKS(STROBE_CLKS), .HOLD_CLKS(HOLD_CLKS)
  ) eng_i (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .rd(eng_rd), .wbyte(eng_wbyte),
    .we_n(nand_we_n), .re_n(nand_re_n), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe),
    .dq_i(nand_dq_i), .rbyte(eng_rbyte), .fin(eng_fin)
  );

  nhb_ready_irq #(.SYNC_STAGES(SYNC_STAGES)) irq_i (
    .clk(clk), .rst_n(rst_n), .rb(nand_rb), .clr_wr(irq_clr), .clr_bit(host_wdata[0]),
    .mask_wr(irq_mwr), .mask_data(host_wdata[7:0]), .busy(st_busy),
    .pend(pend_b), .mask(mask_b), .irq(irq)
  );

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);
  a_r8_ce_gate: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (nand_we_n && nand_re_n));
  a_r13_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BR_IDLE) |-> (nand_we_n && nand_re_n));
endmodule

// File: tb/nand_host_bridge_tb_top.sv
module nand_host_bridge_tb_top;
  localparam int S = 1, P = 3, H = 1, T = S + P + H;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 0, host_wr = 0, host_wide = 0;
  logic [2:0] host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic host_done, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, irq;
  logic [7:0] nand_dq_o, nand_dq_i;
  logic nand_rb = 1'b1;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  nand_host_bridge #(.SETUP_CLKS(S), .STROBE_CLKS(P), .HOLD_CLKS(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wide(host_wide), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_done(host_done), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb), .irq(irq)
  );

  // NAND device model
  logic [7:0] rmem [256];
  logic [7:0] rptr = 0;
  logic [9:0] wlog [256];
  int wcnt = 0, ce_bad = 0;
  assign nand_dq_i = rmem[rptr];
  always @(posedge nand_we_n) if (rst_n === 1'b1) begin
    wlog[wcnt[7:0]] = {nand_cle, nand_ale, nand_dq_o};
    if (nand_ce_n !== 1'b0 || nand_dq_oe !== 1'b1) ce_bad++;
    wcnt++;
  end
  always @(posedge nand_re_n) if (rst_n === 1'b1) rptr = rptr + 1'b1;

  int lowrun = 0, width_bad = 0, both_low = 0, nstrobe = 0;
  always @(negedge clk) if (rst_n) begin
    if (!nand_we_n && !nand_re_n) both_low++;
    if (!nand_we_n || !nand_re_n) lowrun++;
    else if (lowrun > 0) begin
      if (lowrun != P) width_bad++;
      nstrobe++;
      lowrun = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [2:0] a, input bit wide, input logic [15:0] wd,
                     output logic [15:0] rd, output int lat);
    @(negedge clk);
    host_req = 1; host_wr = wr; host_addr = a; host_wide = wide; host_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!host_done && lat < 1000);
    rd = host_rdata;
    host_req = 0;
  endtask

  function automatic logic exp_open(input logic [7:0] m);
    return (m & 8'h90) == 8'h90;
  endfunction

  function automatic int exp_lat(input bit data, input bit open, input bit wide);
    if (!data || !open) return 1;
    return wide ? 2 * T + 1 : T + 1;
  endfunction

  logic [15:0] rd;
  int lat;
  logic [7:0] mode;

  task automatic set_mode(input logic [7:0] m);
    bus(1, 3'd4, 0, {8'h00, m}, rd, lat);
    mode = m;
  endtask

  // one data-port access, checked against the device model
  task automatic data_op(input bit wr, input bit wide, input logic [15:0] wd, input string tag);
    int w0;
    logic [7:0] p0;
    logic [15:0] exp;
    w0 = wcnt; p0 = rptr;
    bus(wr, 3'd0, wide, wd, rd, lat);
    chk(lat == exp_lat(1, exp_open(mode), wide), "R13", lat, exp_lat(1, exp_open(mode), wide));
    if (!exp_open(mode)) begin
      chk(wcnt == w0 && rptr == p0, "R8", wcnt - w0, 0);
      if (!wr) chk(rd == 16'h0, "R8", rd, 0);
    end else if (wr) begin
      chk(wcnt - w0 == (wide ? 2 : 1), tag, wcnt - w0, wide ? 2 : 1);
      chk(wlog[w0[7:0]] == {mode[0], mode[1], wd[7:0]}, tag, wlog[w0[7:0]], {mode[0], mode[1], wd[7:0]});
      if (wide)
        chk(wlog[8'(w0 + 1)] == {mode[0], mode[1], wd[15:8]}, tag, wlog[8'(w0 + 1)], {mode[0], mode[1], wd[15:8]});
    end else begin
      exp = wide ? {rmem[p0 + 8'd1], rmem[p0]} : {8'h00, rmem[p0]};
      chk(rd == exp, "R6", rd, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R13 watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 256; i++) rmem[i] = 8'($urandom);
    mode = 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(nand_ce_n && !nand_cle && !nand_ale && nand_we_n && nand_re_n, "R1",
        {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n}, 5'b10011);
    chk(!irq && !host_done, "R1", {irq, host_done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    bus(0, 3'd4, 0, 0, rd, lat);
    chk(rd == 16'h0, "R1", rd, 0);
    chk(lat == 1, "R13", lat, 1);

    // R2 command phase, R5 single byte
    set_mode(8'h95);
    chk(!nand_ce_n && nand_cle && !nand_ale, "R2", {nand_ce_n, nand_cle, nand_ale}, 3'b010);
    data_op(1, 0, 16'hBE70, "R5");
    set_mode(8'h96);
    chk(!nand_ce_n && !nand_cle && nand_ale, "R2", {nand_ce_n, nand_cle, nand_ale}, 3'b001);
    data_op(1, 0, 16'h0033, "R5");
    set_mode(8'h94);
    chk(!nand_ce_n && !nand_cle && !nand_ale, "R2", {nand_ce_n, nand_cle, nand_ale}, 3'b000);
    data_op(1, 1, 16'hA55A, "R4");
    data_op(0, 1, 0, "R6");
    data_op(0, 0, 0, "R6");

    // R3 readback and extra bits, R8 closed port
    set_mode(8'h6C);
    bus(0, 3'd4, 0, 0, rd, lat);
    chk(rd == 16'h006C, "R3", rd, 16'h6C);
    chk(nand_ce_n == 1'b1, "R2", nand_ce_n, 1);
    data_op(1, 1, 16'h1234, "R8");
    data_op(0, 1, 0, "R8");
    set_mode(8'h14);
    chk(nand_ce_n == 1'b0, "R2", nand_ce_n, 0);
    data_op(1, 0, 16'h0055, "R8");
    data_op(0, 0, 0, "R8");
    set_mode(8'hFC);
    bus(0, 3'd4, 0, 0, rd, lat);
    chk(rd == 16'h00FC, "R3", rd, 16'hFC);
    chk(!nand_cle && !nand_ale && !nand_ce_n, "R3", {nand_cle, nand_ale}, 0);
    data_op(1, 1, 16'hC3E1, "R3");

    // random mix
    for (int i = 0; i < 30; i++) begin
      logic [7:0] m;
      int op;
      m = 8'h90 | (8'($urandom) & 8'h6C) | 8'($urandom_range(0, 2));
      if ($urandom_range(0, 5) == 0) m = m & 8'h6F;
      set_mode(m);
      op = $urandom_range(0, 3);
      data_op(op < 2, op[0], 16'($urandom), (op == 0) ? "R5" : "R4");
    end

    // R9 status, R10..R12 ready interrupt
    nand_rb = 0;
    repeat (4) @(negedge clk);
    bus(0, 3'd5, 0, 0, rd, lat);
    chk(rd == 16'h0080, "R9", rd, 16'h80);
    bus(0, 3'd6, 0, 0, rd, lat);
    chk(rd == 16'h0000, "R10", rd, 0);
    nand_rb = 1;
    repeat (4) @(negedge clk);
    bus(0, 3'd5, 0, 0, rd, lat);
    chk(rd == 16'h0000, "R9", rd, 0);
    bus(0, 3'd6, 0, 0, rd, lat);
    chk(rd == 16'h0001, "R10", rd, 1);
    chk(irq == 1'b0, "R12", irq, 0);
    bus(1, 3'd7, 0, 16'h0081, rd, lat);
    chk(irq == 1'b1, "R12", irq, 1);
    bus(0, 3'd7, 0, 0, rd, lat);
    chk(rd == 16'h0081, "R12", rd, 16'h81);
    bus(1, 3'd7, 0, 16'h0001, rd, lat);
    chk(irq == 1'b0, "R12", irq, 0);
    bus(1, 3'd7, 0, 16'h0081, rd, lat);
    bus(1, 3'd6, 0, 16'h0000, rd, lat);
    bus(0, 3'd6, 0, 0, rd, lat);
    chk(rd == 16'h0001 && irq, "R11", rd, 1);
    bus(1, 3'd6, 0, 16'h000F, rd, lat);
    chk(irq == 1'b0, "R11", irq, 0);
    bus(0, 3'd6, 0, 0, rd, lat);
    chk(rd == 16'h0000, "R11", rd, 0);
    nand_rb = 0;
    repeat (5) @(negedge clk);
    bus(0, 3'd6, 0, 0, rd, lat);
    chk(rd == 16'h0000 && !irq, "R10", rd, 0);
    nand_rb = 1;
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R10", irq, 1);
    bus(1, 3'd7, 0, 16'h0000, rd, lat);
    chk(irq == 1'b0, "R12", irq, 0);

    // R7 strobe shape over the whole run
    chk(width_bad == 0, "R7", width_bad, 0);
    chk(both_low == 0, "R7", both_low, 0);
    chk(ce_bad == 0, "R7", ce_bad, 0);
    chk(nstrobe > 20, "R7", nstrobe, 21);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule